// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block carries a simple 32-bit core from the moment an exception is raised up to the first fetch of its handler. A request is either a fault, which carries a type code, or an interrupt, which carries a priority level and a vector number captured when the interrupt was raised. When the request is accepted, the sequencer copies the status register and works out the updated status value. It then settles the vector number. For an interrupt with acknowledge enabled, that takes a read cycle on the bus.

Next it writes a two-longword exception frame below the supervisor stack pointer. It reads the handler address from a vector table whose base is set in 1 MiB steps, and it returns the handler address, the new status register and the lowered supervisor stack pointer with a one-cycle done pulse. The core keeps its user stack pointer elsewhere. This block never uses it, because every frame goes onto the supervisor stack. The saved PC is the faulting instruction's own address, so that instruction can be restarted later.

All bus traffic uses one memory port with a request/ready handshake and a single transfer in flight. A request raised while a sequence is running is dropped.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `mem_req` and `done` are low. A reset during a sequence abandons that sequence.
- R2: The low 16 bits of the frame's lower longword equal `sr_in` as it was on the cycle the request was accepted, before any bit was changed.
- R3: For every exception, `new_sr` has bit 13 (supervisor) set and bit 15 (trace) cleared. For a fault, every other bit is unchanged.
- R4: For an interrupt, `new_sr` also has bit 12 (master) cleared, and bits 10:8 (priority mask) equal `req_level`.
- R5: For a fault, the vector number is `req_type + FAULT_VEC_OFS` (default 2). The first bus transfer is then the frame write, with no read before it.
- R6: For an interrupt with `ack_enable` set, the first transfer is a read at `IACK_BASE | (req_level << 2)` (default base 0xFFFF_FFE0). Bits 7:0 of the returned data become the vector number.
- R7: For an interrupt with `ack_enable` clear, no acknowledge read occurs and `req_vector` is the vector number.
- R8: The frame takes two writes, in this order: `fault_pc` to `ssp_in-4`, then the format/vector longword to `ssp_in-8`. That longword is {4'h4 in bits 31:28, zeros in 27:26, vector in 25:18, zeros in 17:16, saved SR in 15:0}. `new_ssp` equals `ssp_in-8`, with 32-bit wrap.
- R9: The last transfer is a read at `{vbr_base, 20'b0} + vector*4`. Its data appears on `new_pc` during a done pulse that lasts exactly one cycle, with `mem_req` low.
- R10: A raised `mem_req` keeps its address, direction and write data unchanged until a cycle in which `mem_ready` is high. Any number of wait cycles gives the same result.
- R11: `req_valid` is ignored while a sequence is running. A second request neither alters the frame nor starts extra transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request strobe, sampled when idle |
| req_is_irq | input | 1 | 1 = interrupt, 0 = fault |
| req_type | input | TYPE_W | Fault type code |
| req_level | input | 3 | Interrupt level |
| req_vector | input | 8 | Vector captured when the interrupt was raised |
| ack_enable | input | 1 | Run the acknowledge read for interrupts |
| sr_in | input | 16 | Current status register |
| ssp_in | input | 32 | Current supervisor stack pointer |
| fault_pc | input | 32 | Address of the faulting instruction |
| vbr_base | input | 32-VBR_ALIGN_BITS | Vector table base, upper bits only |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Bus address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Transfer completes on this cycle |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler address |
| new_sr | output | 16 | Updated status register |
| new_ssp | output | 32 | Supervisor stack pointer after the push |

## Verification
On every cycle, the assertions check that a pending request stays stable until `mem_ready`, and that the done pulse is one cycle long with the bus idle. They also check that writes are longword aligned, that every read falls either in the vector table window or in the acknowledge window, and that each finished status word is in supervisor mode with trace off. Some behaviour only the bench's scenarios can show. Which vector source is chosen, the exact frame contents and their order, the masking of the priority level, stack pointer wrap, and the dropping of a request that overlaps a running sequence all depend on the values of a whole sequence. So does a reset in the middle of a sequence.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int AW        = 32;
  localparam int SR_W      = 16;
  localparam int SR_T_BIT  = 15;
  localparam int SR_S_BIT  = 13;
  localparam int SR_M_BIT  = 12;
  localparam int IPL_LO    = 8;
  localparam int IPL_W     = 3;
  localparam int VEC_W     = 8;
  localparam int FRAME_DEC = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_PUSH_PC,
    ST_PUSH_FV,
    ST_FETCH
  } seq_state_e;
endpackage

// File: rtl/exc_sr_update.sv
module exc_sr_update
  import exc_entry_pkg::*;
(
  input  logic [SR_W-1:0]  sr_in,
  input  logic             is_irq,
  input  logic [IPL_W-1:0] level,
  output logic [SR_W-1:0]  sr_out
);
  always_comb begin
    sr_out = sr_in;
    sr_out[SR_S_BIT] = 1'b1;
    sr_out[SR_T_BIT] = 1'b0;
    if (is_irq) begin
      sr_out[SR_M_BIT] = 1'b0;
      sr_out[IPL_LO +: IPL_W] = level;
    end
  end
endmodule

// File: rtl/exc_vec_resolve.sv
module exc_vec_resolve
  import exc_entry_pkg::*;
#(
  parameter int TYPE_W        = 4,
  parameter int FAULT_VEC_OFS = 2
) (
  input  logic              is_irq,
  input  logic              ack_en,
  input  logic [TYPE_W-1:0] ftype,
  input  logic [VEC_W-1:0]  irq_vec,
  output logic [VEC_W-1:0]  vec_out,
  output logic              need_ack
);
  localparam logic [VEC_W-1:0] OFS = VEC_W'(FAULT_VEC_OFS);

  always_comb begin
    need_ack = is_irq & ack_en;
    if (is_irq) vec_out = irq_vec;
    else        vec_out = VEC_W'(ftype) + OFS;
  end
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
  import exc_entry_pkg::*;
#(
  parameter int            VBR_ALIGN_BITS = 20,
  parameter logic [AW-1:0] IACK_BASE      = 32'hFFFF_FFE0
) (
  input  logic [AW-1:0]                ssp,
  input  logic [IPL_W-1:0]             level,
  input  logic [VEC_W-1:0]             vec,
  input  logic [AW-VBR_ALIGN_BITS-1:0] vbr_base,
  output logic [AW-1:0]                ack_addr,
  output logic [AW-1:0]                pc_slot,
  output logic [AW-1:0]                fv_slot,
  output logic [AW-1:0]                tbl_addr
);
  localparam int VBR_W = AW - VBR_ALIGN_BITS;

  always_comb begin
    ack_addr = IACK_BASE | {{(AW-IPL_W-2){1'b0}}, level, 2'b00};
    fv_slot  = ssp - AW'(FRAME_DEC);
    pc_slot  = ssp - AW'(FRAME_DEC/2);
    tbl_addr = {vbr_base, {VBR_ALIGN_BITS{1'b0}}}
             + {{(AW-VEC_W-2){1'b0}}, vec, 2'b00};
  end

  logic unused_w;
  assign unused_w = (VBR_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int            TYPE_W         = 4,
  parameter int            FAULT_VEC_OFS  = 2,
  parameter int            VBR_ALIGN_BITS = 20,
  parameter logic [31:0]   IACK_BASE      = 32'hFFFF_FFE0,
  parameter logic [3:0]    FRAME_FMT      = 4'h4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_is_irq,
  input  logic [TYPE_W-1:0]           req_type,
  input  logic [2:0]                  req_level,
  input  logic [7:0]                  req_vector,
  input  logic                        ack_enable,
  input  logic [15:0]                 sr_in,
  input  logic [31:0]                 ssp_in,
  input  logic [31:0]                 fault_pc,
  input  logic [31-VBR_ALIGN_BITS:0]  vbr_base,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [31:0]                 mem_addr,
  output logic [31:0]                 mem_wdata,
  input  logic [31:0]                 mem_rdata,
  input  logic                        mem_ready,
  output logic                        done,
  output logic [31:0]                 new_pc,
  output logic [15:0]                 new_sr,
  output logic [31:0]                 new_ssp
);
  seq_state_e           state;
  logic [SR_W-1:0]      sr_saved, sr_next_q, sr_upd;
  logic [VEC_W-1:0]     vec_q, vec_init;
  logic [IPL_W-1:0]     lvl_q;
  logic [AW-1:0]        pc_q, ssp_q;
  logic                 need_ack;

  // selected sources: live inputs while idle, captured copies afterwards
  logic                 idle;
  logic [AW-1:0]        ssp_sel;
  logic [IPL_W-1:0]     lvl_sel;
  logic [AW-1:0]        ack_addr, pc_slot, fv_slot, tbl_addr;
  logic [AW-1:0]        fv_word;

  assign idle    = (state == ST_IDLE);
  assign ssp_sel = idle ? ssp_in    : ssp_q;
  assign lvl_sel = idle ? req_level : lvl_q;
  assign fv_word = {FRAME_FMT, 2'b00, vec_q, 2'b00, sr_saved};

  exc_sr_update u_sr (
    .sr_in  (sr_in),
    .is_irq (req_is_irq),
    .level  (req_level),
    .sr_out (sr_upd)
  );

  exc_vec_resolve #(
    .TYPE_W        (TYPE_W),
    .FAULT_VEC_OFS (FAULT_VEC_OFS)
  ) u_vec (
    .is_irq   (req_is_irq),
    .ack_en   (ack_enable),
    .ftype    (req_type),
    .irq_vec  (req_vector),
    .vec_out  (vec_init),
    .need_ack (need_ack)
  );

  exc_addr_gen #(
    .VBR_ALIGN_BITS (VBR_ALIGN_BITS),
    .IACK_BASE      (IACK_BASE)
  ) u_addr (
    .ssp      (ssp_sel),
    .level    (lvl_sel),
    .vec      (vec_q),
    .vbr_base (vbr_base),
    .ack_addr (ack_addr),
    .pc_slot  (pc_slot),
    .fv_slot  (fv_slot),
    .tbl_addr (tbl_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      new_pc    <= '0;
      new_sr    <= '0;
      new_ssp   <= '0;
      sr_saved  <= '0;
      sr_next_q <= '0;
      vec_q     <= '0;
      lvl_q     <= '0;
      pc_q      <= '0;
      ssp_q     <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            sr_saved  <= sr_in;
            sr_next_q <= sr_upd;
            vec_q     <= vec_init;
            lvl_q     <= req_level;
            pc_q      <= fault_pc;
            ssp_q     <= ssp_in;
            mem_req   <= 1'b1;
            if (need_ack) begin
              state     <= ST_ACK;
              mem_we    <= 1'b0;
              mem_addr  <= ack_addr;
              mem_wdata <= '0;
            end else begin
              state     <= ST_PUSH_PC;
              mem_we    <= 1'b1;
              mem_addr  <= pc_slot;
              mem_wdata <= fault_pc;
            end
          end
        end
        ST_ACK: begin
          if (mem_ready) begin
            vec_q     <= mem_rdata[VEC_W-1:0];
            state     <= ST_PUSH_PC;
            mem_we    <= 1'b1;
            mem_addr  <= pc_slot;
            mem_wdata <= pc_q;
          end
        end
        ST_PUSH_PC: begin
          if (mem_ready) begin
            state     <= ST_PUSH_FV;
            mem_addr  <= fv_slot;
            mem_wdata <= fv_word;
          end
        end
        ST_PUSH_FV: begin
          if (mem_ready) begin
            state     <= ST_FETCH;
            mem_we    <= 1'b0;
            mem_addr  <= tbl_addr;
            mem_wdata <= '0;
          end
        end
        ST_FETCH: begin
          if (mem_ready) begin
            state   <= ST_IDLE;
            mem_req <= 1'b0;
            done    <= 1'b1;
            new_pc  <= mem_rdata;
            new_sr  <= sr_next_q;
            new_ssp <= fv_slot;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int          VBR_ALIGN_BITS = 20,
  parameter logic [31:0] IACK_BASE      = 32'hFFFF_FFE0
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       mem_req,
  input logic                       mem_we,
  input logic                       mem_ready,
  input logic [31:0]                mem_addr,
  input logic [31:0]                mem_wdata,
  input logic                       done,
  input logic [15:0]                new_sr,
  input logic [31-VBR_ALIGN_BITS:0] vbr_base
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!mem_req && !done)); // R1
  AST_SUPER_MODE: assert property (@(posedge clk) disable iff (rst)
    done |-> ((new_sr & 16'hA000) == 16'h2000)); // R3
  AST_WRITE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[1:0] == 2'b00)); // R8
  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> ((mem_addr[31:VBR_ALIGN_BITS] == vbr_base) ||
                              (mem_addr[31:5] == IACK_BASE[31:5]))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req); // R9
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata))); // R10
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .VBR_ALIGN_BITS (VBR_ALIGN_BITS),
  .IACK_BASE      (IACK_BASE)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .new_sr    (new_sr),
  .vbr_base  (vbr_base)
);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_is_irq = 1'b0, ack_enable = 1'b0;
  logic [3:0]  req_type = '0;
  logic [2:0]  req_level = '0;
  logic [7:0]  req_vector = '0;
  logic [15:0] sr_in = '0;
  logic [31:0] ssp_in = '0, fault_pc = '0;
  logic [11:0] vbr_base = '0;
  logic        mem_req, mem_we, done;
  logic [31:0] mem_addr, mem_wdata, new_pc, new_ssp;
  logic [15:0] new_sr;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  always #4 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_irq(req_is_irq),
    .req_type(req_type), .req_level(req_level), .req_vector(req_vector),
    .ack_enable(ack_enable), .sr_in(sr_in), .ssp_in(ssp_in), .fault_pc(fault_pc),
    .vbr_base(vbr_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .done(done), .new_pc(new_pc), .new_sr(new_sr), .new_ssp(new_ssp)
  );

  typedef struct packed {
    logic        irq;
    logic [3:0]  ftype;
    logic [2:0]  lvl;
    logic [7:0]  lvec;
    logic        ack;
    logic [15:0] sr;
    logic [31:0] ssp;
    logic [31:0] pc;
    logic [11:0] vbr;
    logic [3:0]  wt;
  } ent_t;

  localparam int NENT = 6;
  localparam ent_t TBL [NENT] = '{
    '{1'b0, 4'd1,  3'd0, 8'h00, 1'b0, 16'h8700, 32'h0000_8000, 32'h0000_1234, 12'h001, 4'd0},
    '{1'b0, 4'd15, 3'd0, 8'h00, 1'b0, 16'h3000, 32'h2000_0100, 32'h0001_0000, 12'h000, 4'd2},
    '{1'b1, 4'd0,  3'd5, 8'h11, 1'b1, 16'h1000, 32'h0000_4000, 32'hCAFE_0000, 12'h123, 4'd1},
    '{1'b1, 4'd0,  3'd7, 8'h64, 1'b0, 16'hA300, 32'h0010_0008, 32'h0000_0100, 12'h7FF, 4'd0},
    '{1'b1, 4'd0,  3'd1, 8'h22, 1'b1, 16'h0000, 32'h0000_0008, 32'h0000_0000, 12'h800, 4'd3},
    '{1'b1, 4'd0,  3'd3, 8'hFF, 1'b0, 16'hFFFF, 32'h0000_0000, 32'hFFFF_FFFE, 12'hFFE, 4'd0}
  };

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [3:0] wt_cfg = '0;
  int wt_cnt = 0;
  logic [31:0] lg_addr [8];
  logic        lg_we   [8];
  logic [31:0] lg_wd   [8];
  int lg_n = 0;

  function automatic logic [31:0] tbl_data(input logic [31:0] a);
    return a ^ 32'h5A5A_5A5A;
  endfunction

  // bus responder: drives ready at negedge, completion happens on the next posedge
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      wt_cnt    <= 0;
    end else if (mem_req) begin
      if (wt_cnt >= int'(wt_cfg)) begin
        mem_ready <= 1'b1;
        if (mem_addr[31:5] == 27'h7FF_FFFF)
          mem_rdata <= 32'hABCD_0000 | {24'h0, 8'h40 + {5'b0, mem_addr[4:2]}};
        else
          mem_rdata <= tbl_data(mem_addr);
        if (lg_n < 8) begin
          lg_addr[lg_n] = mem_addr;
          lg_we[lg_n]   = mem_we;
          lg_wd[lg_n]   = mem_wdata;
        end
        lg_n = lg_n + 1;
      end else begin
        wt_cnt <= wt_cnt + 1;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  task automatic drive_req(input ent_t e);
    req_is_irq = e.irq; req_type = e.ftype; req_level = e.lvl; req_vector = e.lvec;
    ack_enable = e.ack; sr_in = e.sr; ssp_in = e.ssp; fault_pc = e.pc;
    vbr_base = e.vbr; wt_cfg = e.wt; lg_n = 0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin ok = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic run_entry(input ent_t e);
    logic [7:0]  v;
    logic [15:0] xs;
    logic [31:0] xa [4];
    logic        xw [4];
    logic [31:0] xd [4];
    string       xt [4];
    int          nx;
    bit          ok;
    v  = !e.irq ? (8'(e.ftype) + 8'd2) : (e.ack ? (8'h40 + {5'b0, e.lvl}) : e.lvec);
    xs = e.sr | 16'h2000;
    xs[15] = 1'b0;
    if (e.irq) begin xs[12] = 1'b0; xs[10:8] = e.lvl; end
    nx = 0;
    if (e.irq && e.ack) begin
      xa[nx] = 32'hFFFF_FFE0 | {27'b0, e.lvl, 2'b00}; xw[nx] = 1'b0; xd[nx] = '0;
      xt[nx] = "R6"; nx++;
    end
    xa[nx] = e.ssp - 32'd4; xw[nx] = 1'b1; xd[nx] = e.pc; xt[nx] = "R8"; nx++;
    xa[nx] = e.ssp - 32'd8; xw[nx] = 1'b1; xd[nx] = {4'h4, 2'b00, v, 2'b00, e.sr};
    xt[nx] = !e.irq ? "R5" : (e.ack ? "R6" : "R7"); nx++;
    xa[nx] = {e.vbr, 20'b0} + {22'b0, v, 2'b00}; xw[nx] = 1'b0; xd[nx] = '0;
    xt[nx] = "R9"; nx++;

    drive_req(e);
    wait_done(ok);
    chk("R9 done seen", 32'(ok), 32'd1);
    chk((e.irq && !e.ack) ? "R7 transfer count" : "R8 transfer count", lg_n, nx);
    if (!e.irq) chk("R5 first transfer is write", 32'(lg_we[0]), 32'd1);
    if (lg_n == nx) begin
      for (int k = 0; k < nx; k++) begin
        chk({xt[k], " addr"}, lg_addr[k], xa[k]);
        chk({xt[k], " dir"}, 32'(lg_we[k]), 32'(xw[k]));
        if (xw[k]) chk({xt[k], " wdata"}, lg_wd[k], xd[k]);
      end
      chk("R2 saved sr", {16'h0, lg_wd[nx-2][15:0]}, {16'h0, e.sr});
    end
    chk(e.wt != 0 ? "R10 new_pc with waits" : "R9 new_pc", new_pc, tbl_data(xa[nx-1]));
    chk(e.irq ? "R4 new_sr" : "R3 new_sr", {16'h0, new_sr}, {16'h0, xs});
    chk("R8 new_ssp", new_ssp, e.ssp - 32'd8);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    bit ok;
    ent_t e;
    int quiet;
    repeat (3) @(negedge clk);
    chk("R1 reset mem_req", 32'(mem_req), 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NENT; i++) run_entry(TBL[i]);

    // R11: second request while busy is dropped
    e = TBL[1];
    e.wt = 4'd2;
    drive_req(e);
    @(negedge clk);
    req_valid = 1'b1; fault_pc = 32'h7777_0000; req_type = 4'd9;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(ok);
    chk("R11 done", 32'(ok), 32'd1);
    chk("R11 transfer count", lg_n, 3);
    chk("R11 pc kept", lg_wd[0], e.pc);
    chk("R11 vector kept", {24'h0, lg_wd[1][25:18]}, 32'd17);
    quiet = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (mem_req) quiet++;
    end
    chk("R11 no extra request", quiet, 0);

    // R1: reset in the middle of a sequence
    e = TBL[2];
    e.wt = 4'd3;
    drive_req(e);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset mem_req", 32'(mem_req), 32'd0);
    chk("R1 mid reset done", 32'(done), 32'd0);
    rst = 1'b0;
    wt_cfg = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1 stays idle", 32'(mem_req), 32'd0);
    run_entry(TBL[0]);

    finish_run();
  end
endmodule